// File: doc/BRIEF.md
# TDM Serial Frame Timing Recovery

This block sits behind the pins of a time-division-multiplexed serial port and turns the external channel clock, frame sync and data line into per-bit events in the system clock domain. It serves one direction. All three pin signals are oversampled by the faster system clock. The block finds the channel-clock edges on which data is valid and detects the start of each frame from the sync line. It then skips a programmable number of bit periods before it declares bit 0 of slot 0.

For every recovered bit it raises a one-cycle strobe. With the strobe it presents the data level, the bit position inside the 8-bit slot and the slot number. The first bit of each frame is also flagged. Downstream logic uses these outputs to route slots or to load transmit bits. The data edge, sync sampling edge, sync polarity, double-rate clocking and the sync delay are run-time inputs. They are meant to change only while reset is held. A pin-select input chooses between the direction's own clock/sync pair and a pair shared by both directions.

Top module: `tdm_frame_timer`

## Requirements
- R1: While reset is held, and on its release, `bit_stb_o` and `frame_start_o` are 0 and both index outputs read 0.
- R2: Each recovered bit is taken on a sample edge of the channel clock. With `cfg_drive_fall`=1 the sample edge is the rising edge; with 0 it is the falling edge. `bit_o` equals the data line level at that edge. Each strobe lasts one system cycle.
- R3: The frame sync is examined only on channel-clock rising edges when `cfg_sync_rise`=1, and only on falling edges when it is 0.
- R4: With `cfg_sync_low`=1 a sync is a low level on the sync line, and with 0 it is a high level. A frame starts only when the level seen at consecutive sync-sampling edges goes from inactive to active. A sync held active over several edges starts one frame.
- R5: `cfg_sync_dly` (0 to 3) sets how many bit periods are skipped, and produce no strobe, after a detected sync. The next bit period is bit 0 of slot 0. When a sample edge coincides with the detecting edge, that edge is the first bit period counted.
- R6: With `cfg_dbl_speed`=1, one bit is recovered for every two sample edges. The pairing restarts at a detected sync, so the first sample edge at or after the sync begins a bit period.
- R7: Bit index 0 carries the most significant bit of a slot. The index runs 0 to 7 and then returns to 0 while the slot index increments. The first bit of a frame has `frame_start_o`=1 with both indices 0.
- R8: A sync detected while a frame is running abandons it. Strobes stop until the first bit of the new frame, which again starts at slot 0.
- R9: No strobe occurs before the first detected sync. If no further sync arrives, bits keep being reported up to bit 7 of slot 63, and none after that until a new frame starts.
- R10: With `cfg_shared_pins`=1 the clock and sync come from `shr_clk_i`/`shr_sync_i`, and activity on `ded_clk_i`/`ded_sync_i` has no effect. With 0 the reverse holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the channel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shared_pins | input | 1 | 1: use shared clock/sync pair, 0: dedicated pair |
| ded_clk_i | input | 1 | Dedicated channel clock pin |
| ded_sync_i | input | 1 | Dedicated frame sync pin |
| shr_clk_i | input | 1 | Shared channel clock pin |
| shr_sync_i | input | 1 | Shared frame sync pin |
| ser_data_i | input | 1 | Serial data pin |
| cfg_drive_fall | input | 1 | 1: sample on rising, drive on falling edge |
| cfg_sync_rise | input | 1 | 1: sync sampled on rising edge |
| cfg_sync_low | input | 1 | 1: sync active low |
| cfg_dbl_speed | input | 1 | 1: channel clock at twice the bit rate |
| cfg_sync_dly | input | 2 | Bit periods from sync to first bit |
| bit_stb_o | output | 1 | One-cycle strobe per recovered bit |
| bit_o | output | 1 | Data bit for the strobe |
| bit_idx_o | output | 3 | Bit position within the slot |
| slot_idx_o | output | 6 | Slot number within the frame |
| frame_start_o | output | 1 | Strobe is the first bit of a frame |

## Verification
Two situations are the hardest to reach from the pins. In the first, the sync-sampling edge and the data-sampling edge fall in the same system cycle while a delay or double-rate pairing is active. This decides whether the coinciding edge counts as the first bit period. In the second, a running frame exhausts all 64 slots. The stimulus covers the first with directed cases for every delay under both edge selections, and with random configurations in which the two selections agree or differ. For the second, a frame receives a single sync and is then clocked for more than 512 bit periods.

// File: rtl/tdm_ft_pkg.sv
package tdm_ft_pkg;

    // Per-system-cycle events produced by the pin front end.
    typedef struct packed {
        logic smp;      // a data sample edge of the channel clock
        logic sync_det; // inactive-to-active sync seen on a sync edge
        logic dat;      // data line level aligned with smp
    } tdm_evt_t;

endpackage

// File: rtl/tdm_ft_sync.sv
module tdm_ft_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.stg[STAGES-1];
endmodule

// File: rtl/tdm_ft_edge.sv
module tdm_ft_edge
    import tdm_ft_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     s_clk_i,
    input  logic     s_sync_i,
    input  logic     s_dat_i,
    input  logic     cfg_drive_fall,
    input  logic     cfg_sync_rise,
    input  logic     cfg_sync_low,
    output tdm_evt_t evt_o
);
    typedef struct packed {
        logic clk_prev; // previous synchronized channel clock
        logic act_last; // sync activity seen at the last sync edge
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic rise, fall, sync_edge, act;

    always_comb begin
        st_d      = st_q;
        rise      = s_clk_i & ~st_q.clk_prev;
        fall      = ~s_clk_i & st_q.clk_prev;
        sync_edge = cfg_sync_rise ? rise : fall;
        act       = s_sync_i ^ cfg_sync_low;

        st_d.clk_prev = s_clk_i;
        if (sync_edge) st_d.act_last = act;

        evt_o.smp      = cfg_drive_fall ? rise : fall;
        evt_o.sync_det = sync_edge & act & ~st_q.act_last;
        evt_o.dat      = s_dat_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tdm_ft_count.sv
module tdm_ft_count
    import tdm_ft_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned MAX_SLOTS = 64,
    parameter int unsigned DLY_W     = 2,
    localparam int unsigned BIT_W    = $clog2(SLOT_BITS),
    localparam int unsigned SLOT_W   = $clog2(MAX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tdm_evt_t          evt_i,
    input  logic              cfg_dbl_speed,
    input  logic [DLY_W-1:0]  cfg_sync_dly,
    output logic              bit_stb_o,
    output logic              bit_o,
    output logic [BIT_W-1:0]  bit_idx_o,
    output logic [SLOT_W-1:0] slot_idx_o,
    output logic              frame_start_o
);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(MAX_SLOTS - 1);

    typedef struct packed {
        logic              half;  // double-rate: second edge of a bit pending
        logic              pend;  // sync seen, frame not started yet
        logic [DLY_W-1:0]  skip;  // bit periods still to skip
        logic              run;   // a frame is being counted
        logic [BIT_W-1:0]  nxt_b; // index of the next bit
        logic [SLOT_W-1:0] nxt_s; // slot of the next bit
        logic              stb;
        logic              dat;
        logic [BIT_W-1:0]  bidx;
        logic [SLOT_W-1:0] sidx;
        logic              fs;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic             half_eff, pend_eff, bit_evt;
    logic [DLY_W-1:0] skip_eff;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        st_d.fs  = 1'b0;

        half_eff = evt_i.sync_det ? 1'b0 : st_q.half;
        pend_eff = evt_i.sync_det | st_q.pend;
        skip_eff = evt_i.sync_det ? cfg_sync_dly : st_q.skip;
        bit_evt  = evt_i.smp & (~cfg_dbl_speed | ~half_eff);

        st_d.half = evt_i.smp ? ~half_eff : half_eff;
        st_d.pend = pend_eff;
        st_d.skip = skip_eff;

        if (bit_evt) begin
            if (pend_eff) begin
                if (skip_eff == '0) begin
                    st_d.pend  = 1'b0;
                    st_d.run   = 1'b1;
                    st_d.stb   = 1'b1;
                    st_d.fs    = 1'b1;
                    st_d.dat   = evt_i.dat;
                    st_d.bidx  = '0;
                    st_d.sidx  = '0;
                    st_d.nxt_b = BIT_W'(1);
                    st_d.nxt_s = '0;
                end else begin
                    st_d.skip = skip_eff - DLY_W'(1);
                end
            end else if (st_q.run) begin
                st_d.stb  = 1'b1;
                st_d.dat  = evt_i.dat;
                st_d.bidx = st_q.nxt_b;
                st_d.sidx = st_q.nxt_s;
                if (st_q.nxt_b == LAST_BIT) begin
                    st_d.nxt_b = '0;
                    if (st_q.nxt_s == LAST_SLOT) st_d.run   = 1'b0;
                    else                         st_d.nxt_s = st_q.nxt_s + SLOT_W'(1);
                end else begin
                    st_d.nxt_b = st_q.nxt_b + BIT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_stb_o     = st_q.stb;
    assign bit_o         = st_q.dat;
    assign bit_idx_o     = st_q.bidx;
    assign slot_idx_o    = st_q.sidx;
    assign frame_start_o = st_q.fs;
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_ft_pkg::*;
#(
    parameter int unsigned SLOT_BITS   = 8,
    parameter int unsigned MAX_SLOTS   = 64,
    parameter int unsigned DLY_W       = 2,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned BIT_W      = $clog2(SLOT_BITS),
    localparam int unsigned SLOT_W     = $clog2(MAX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_shared_pins,
    input  logic              ded_clk_i,
    input  logic              ded_sync_i,
    input  logic              shr_clk_i,
    input  logic              shr_sync_i,
    input  logic              ser_data_i,
    input  logic              cfg_drive_fall,
    input  logic              cfg_sync_rise,
    input  logic              cfg_sync_low,
    input  logic              cfg_dbl_speed,
    input  logic [DLY_W-1:0]  cfg_sync_dly,
    output logic              bit_stb_o,
    output logic              bit_o,
    output logic [BIT_W-1:0]  bit_idx_o,
    output logic [SLOT_W-1:0] slot_idx_o,
    output logic              frame_start_o
);
    logic [2:0] pin_raw, pin_syn;
    tdm_evt_t   evt;
    logic       smp_edge;

    assign pin_raw[0] = cfg_shared_pins ? shr_clk_i  : ded_clk_i;
    assign pin_raw[1] = cfg_shared_pins ? shr_sync_i : ded_sync_i;
    assign pin_raw[2] = ser_data_i;

    tdm_ft_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_raw),
        .q_o   (pin_syn)
    );

    tdm_ft_edge u_edge (
        .clk            (clk),
        .rst_n          (rst_n),
        .s_clk_i        (pin_syn[0]),
        .s_sync_i       (pin_syn[1]),
        .s_dat_i        (pin_syn[2]),
        .cfg_drive_fall (cfg_drive_fall),
        .cfg_sync_rise  (cfg_sync_rise),
        .cfg_sync_low   (cfg_sync_low),
        .evt_o          (evt)
    );

    assign smp_edge = evt.smp;

    tdm_ft_count #(
        .SLOT_BITS (SLOT_BITS),
        .MAX_SLOTS (MAX_SLOTS),
        .DLY_W     (DLY_W)
    ) u_count (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_i         (evt),
        .cfg_dbl_speed (cfg_dbl_speed),
        .cfg_sync_dly  (cfg_sync_dly),
        .bit_stb_o     (bit_stb_o),
        .bit_o         (bit_o),
        .bit_idx_o     (bit_idx_o),
        .slot_idx_o    (slot_idx_o),
        .frame_start_o (frame_start_o)
    );
endmodule

// File: rtl/tdm_frame_timer_chk.sv
module tdm_frame_timer_chk #(
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned MAX_SLOTS = 64,
    localparam int unsigned BIT_W    = $clog2(SLOT_BITS),
    localparam int unsigned SLOT_W   = $clog2(MAX_SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_edge,
    input logic              cfg_dbl_speed,
    input logic              bit_stb_o,
    input logic              frame_start_o,
    input logic [BIT_W-1:0]  bit_idx_o,
    input logic [SLOT_W-1:0] slot_idx_o
);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(MAX_SLOTS - 1);

    logic              seen_q, done_q;
    logic [BIT_W-1:0]  lb_q;
    logic [SLOT_W-1:0] ls_q;
    logic [1:0]        edges_q;
    logic [BIT_W-1:0]  exp_b;
    logic [SLOT_W-1:0] exp_s;

    assign exp_b = (lb_q == LAST_BIT) ? '0 : lb_q + BIT_W'(1);
    assign exp_s = (lb_q == LAST_BIT) ? ls_q + SLOT_W'(1) : ls_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            done_q  <= 1'b0;
            lb_q    <= '0;
            ls_q    <= '0;
            edges_q <= '0;
        end else begin
            if (bit_stb_o) begin
                seen_q  <= 1'b1;
                lb_q    <= bit_idx_o;
                ls_q    <= slot_idx_o;
                done_q  <= (bit_idx_o == LAST_BIT) && (slot_idx_o == LAST_SLOT);
                edges_q <= {1'b0, smp_edge};
            end else if (smp_edge && edges_q != 2'd3) begin
                edges_q <= edges_q + 2'd1;
            end
        end
    end

    assert_fs_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> (bit_stb_o && bit_idx_o == '0 && slot_idx_o == '0));

    assert_idx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb_o && !frame_start_o && seen_q) |-> (bit_idx_o == exp_b && slot_idx_o == exp_s));

    assert_first_is_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb_o && !seen_q) |-> frame_start_o);

    assert_stop_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb_o && done_q) |-> frame_start_o);

    assert_stb_from_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |-> $past(smp_edge));

    assert_dbl_pairs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb_o && !frame_start_o && seen_q && cfg_dbl_speed) |-> (edges_q >= 2'd2));
endmodule

bind tdm_frame_timer tdm_frame_timer_chk #(
    .SLOT_BITS (SLOT_BITS),
    .MAX_SLOTS (MAX_SLOTS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_edge      (smp_edge),
    .cfg_dbl_speed (cfg_dbl_speed),
    .bit_stb_o     (bit_stb_o),
    .frame_start_o (frame_start_o),
    .bit_idx_o     (bit_idx_o),
    .slot_idx_o    (slot_idx_o)
);

// File: tb/tb_tdm_frame_timer.sv
module tb_tdm_frame_timer;
    localparam int NC   = 700;
    localparam int NE   = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_shared_pins = 1'b0;
    logic cfg_drive_fall = 1'b0, cfg_sync_rise = 1'b0, cfg_sync_low = 1'b0, cfg_dbl_speed = 1'b0;
    logic [1:0] cfg_sync_dly = 2'd0;
    logic w_clk = 1'b0, w_sync = 1'b0, w_dat = 1'b0;
    logic j_clk = 1'b0, j_sync = 1'b0;
    logic ded_clk_i, ded_sync_i, shr_clk_i, shr_sync_i;
    logic bit_stb_o, bit_o, frame_start_o;
    logic [2:0] bit_idx_o;
    logic [5:0] slot_idx_o;

    always #5 clk = ~clk;

    assign ded_clk_i  = cfg_shared_pins ? j_clk  : w_clk;
    assign ded_sync_i = cfg_shared_pins ? j_sync : w_sync;
    assign shr_clk_i  = cfg_shared_pins ? w_clk  : j_clk;
    assign shr_sync_i = cfg_shared_pins ? w_sync : j_sync;

    tdm_frame_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_shared_pins(cfg_shared_pins),
        .ded_clk_i(ded_clk_i), .ded_sync_i(ded_sync_i),
        .shr_clk_i(shr_clk_i), .shr_sync_i(shr_sync_i),
        .ser_data_i(w_dat), .cfg_drive_fall(cfg_drive_fall),
        .cfg_sync_rise(cfg_sync_rise), .cfg_sync_low(cfg_sync_low),
        .cfg_dbl_speed(cfg_dbl_speed), .cfg_sync_dly(cfg_sync_dly),
        .bit_stb_o(bit_stb_o), .bit_o(bit_o), .bit_idx_o(bit_idx_o),
        .slot_idx_o(slot_idx_o), .frame_start_o(frame_start_o)
    );

    int n_chk = 0, n_fail = 0;
    bit sa [NC];
    bit de [2*NC];
    int e_n, a_n;
    logic [10:0] e_v [NE];
    logic [10:0] a_v [NE];
    bit junk_en = 1'b0;

    // Unused pin pair gets noise (R10).
    always @(negedge clk) begin
        if (junk_en) begin
            j_clk  <= ~j_clk;
            j_sync <= $urandom_range(0, 1) == 1;
        end
    end

    // Record every strobe: {dat, fs, slot[5:0], bit[2:0]}.
    always @(negedge clk) begin
        if (rst_n && bit_stb_o && a_n < NE) begin
            a_v[a_n] = {bit_o, frame_start_o, slot_idx_o, bit_idx_o};
            a_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void emit(bit d, bit fs, int s, int b);
        if (e_n < NE) e_v[e_n] = {d, fs, 6'(s), 3'(b)};
        e_n++;
    endfunction

    // Expected strobes from the requirement rules, edges in pin order.
    function automatic void model(int ncyc);
        bit last = 0, half = 0, pend = 0, run = 0;
        int skip = 0, nb = 0, ns = 0;
        e_n = 0;
        for (int k = 0; k < ncyc; k++) begin
            for (int e = 0; e < 2; e++) begin
                bit is_rise = (e == 0);
                bit smp = cfg_drive_fall ? is_rise : !is_rise;
                bit sed = cfg_sync_rise ? is_rise : !is_rise;
                bit det = 0, bev = 0;
                bit d = de[2*k+e];
                if (sed) begin
                    det = sa[k] && !last;
                    last = sa[k];
                end
                if (det) begin half = 0; pend = 1; skip = cfg_sync_dly; end
                if (smp) begin
                    bev = !cfg_dbl_speed || !half;
                    half = !half;
                end
                if (bev) begin
                    if (pend) begin
                        if (skip == 0) begin
                            pend = 0; run = 1; emit(d, 1, 0, 0); nb = 1; ns = 0;
                        end else skip--;
                    end else if (run) begin
                        emit(d, 0, ns, nb);
                        if (nb == 7) begin
                            nb = 0;
                            if (ns == 63) run = 0; else ns++;
                        end else nb++;
                    end
                end
            end
        end
    endfunction

    task automatic fill(int ncyc);
        for (int k = 0; k < NC; k++) sa[k] = 0;
        for (int i = 0; i < 2*ncyc; i++) de[i] = $urandom_range(0, 1) == 1;
    endtask

    task automatic put_sync(int k, int len);
        for (int i = 0; i < len; i++) if (k + i < NC) sa[k+i] = 1;
    endtask

    task automatic run_case(input string req, input int ncyc);
        rst_n = 1'b0;
        w_clk = 1'b0; w_sync = cfg_sync_low; w_dat = 1'b0;
        junk_en = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        a_n = 0;
        model(ncyc);
        for (int k = 0; k < ncyc; k++) begin
            w_sync = sa[k] ^ cfg_sync_low; w_dat = de[2*k];
            repeat (2) @(negedge clk);
            w_clk = 1'b1;
            repeat (2) @(negedge clk);
            w_dat = de[2*k+1];
            repeat (2) @(negedge clk);
            w_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk(a_n == e_n, req, "strobe count", a_n, e_n);
        for (int i = 0; i < a_n && i < e_n && i < NE; i++)
            chk(a_v[i] === e_v[i], req, $sformatf("strobe %0d {dat,fs,slot,bit}", i), int'(a_v[i]), int'(e_v[i]));
    endtask

    task automatic set_cfg(bit df, bit sr, bit sl, bit db, int dl, bit sh);
        cfg_drive_fall = df; cfg_sync_rise = sr; cfg_sync_low = sl;
        cfg_dbl_speed = db; cfg_sync_dly = 2'(dl); cfg_shared_pins = sh;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state with pins active
        rst_n = 1'b0; junk_en = 1'b1;
        repeat (3) @(negedge clk);
        w_clk = 1'b1; w_sync = 1'b1;
        repeat (6) @(negedge clk);
        chk({bit_stb_o, frame_start_o, bit_idx_o, slot_idx_o} == '0, "R1", "outputs in reset",
            int'({bit_stb_o, frame_start_o, bit_idx_o, slot_idx_o}), 0);
        w_clk = 1'b0; w_sync = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({bit_stb_o, frame_start_o, bit_idx_o, slot_idx_o} == '0, "R1", "outputs after release",
            int'({bit_stb_o, frame_start_o, bit_idx_o, slot_idx_o}), 0);

        // R2 R7: default edges, one sync
        set_cfg(0, 0, 0, 0, 0, 0); fill(30); put_sync(3, 1); run_case("R2_R7", 30);
        // R2 R3: rising sample edge, both sync edges
        set_cfg(1, 0, 0, 0, 0, 0); fill(30); put_sync(4, 1); run_case("R2_R3", 30);
        set_cfg(1, 1, 0, 0, 0, 0); fill(30); put_sync(4, 1); run_case("R3", 30);
        set_cfg(0, 1, 0, 0, 0, 0); fill(30); put_sync(4, 1); run_case("R3", 30);
        // R5: every delay, coincident and opposite edges
        for (int dl = 0; dl < 4; dl++) begin
            set_cfg(1, 1, 0, 0, dl, 0); fill(30); put_sync(2, 1); run_case("R5", 30);
            set_cfg(0, 1, 0, 0, dl, 0); fill(30); put_sync(2, 1); run_case("R5", 30);
        end
        // R4: active low, long sync counts once
        set_cfg(0, 0, 1, 0, 1, 0); fill(40); put_sync(3, 5); run_case("R4", 40);
        set_cfg(1, 1, 0, 0, 0, 0); fill(40); put_sync(3, 5); run_case("R4", 40);
        // R6: double rate
        set_cfg(0, 0, 0, 1, 2, 0); fill(60); put_sync(2, 1); run_case("R6", 60);
        set_cfg(1, 1, 0, 1, 0, 0); fill(60); put_sync(3, 1); run_case("R6", 60);
        // R8: resync mid-frame
        set_cfg(0, 1, 0, 0, 1, 0); fill(90); put_sync(3, 1); put_sync(40, 1); run_case("R8", 90);
        // R9: free run to last slot then stop
        set_cfg(1, 0, 0, 0, 3, 0); fill(540); put_sync(4, 1); run_case("R9", 540);
        // R10: shared pin pair, noise on dedicated
        set_cfg(0, 0, 1, 0, 2, 1); fill(40); put_sync(3, 2); run_case("R10", 40);
        set_cfg(1, 1, 0, 1, 1, 1); fill(40); put_sync(5, 1); run_case("R10", 40);
        // R7: random configurations and sync placement
        for (int t = 0; t < 20; t++) begin
            int nc = $urandom_range(60, 150);
            int ns = $urandom_range(1, 3);
            set_cfg($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                    $urandom_range(0, 1) == 1, $urandom_range(0, 3), $urandom_range(0, 1) == 1);
            fill(nc);
            for (int s = 0; s < ns; s++) put_sync($urandom_range(1, nc - 10), $urandom_range(1, 3));
            run_case("R7", nc);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule